// File: doc/BRIEF.md
# Dual-Channel Converter Serial Load Interface

This block is the digital front end of a two-channel 8-bit converter. A host writes 16-bit words over a three-wire serial link made of an active-low select, a serial clock and a data line. Each word carries a 4-bit command, four reserved bits and an 8-bit code. The command sends the code to one of three holding registers: channel A, channel B, or a staging register shared by both channels. Two 8-bit outputs carry the codes that drive the two converters.

The staging register makes a paired update possible. The host first writes the new channel A code into the staging register. It then issues the channel B command, which loads channel B and copies the staged code into channel A in the same system clock cycle. Either channel can also be loaded on its own.

All three serial lines are resynchronised into the system clock domain. A word takes effect on its sixteenth bit. It can also take effect early, when the select line is released after at least eight bits have been received. An asynchronous active-low reset clears every register to zero, the same clearing that happens at power-up.

Top module: `dual_dac_serial_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `code_a`, `code_b` and the staging register all hold 0. After reset, a channel B command with no prior staging write drives `code_a` to 0.
- R2: Serial clock activity while `cs_n` is high shifts nothing in and changes no output. The next framed word is decoded exactly as if that activity had not happened.
- R3: Bits are taken most significant first, one on each falling edge of `sclk` while `cs_n` is low. Word bit 15 is the first bit. Bits 15:12 are the command, bits 11:8 are reserved and ignored, and bits 7:0 are the code.
- R4: A word commits on its sixteenth falling edge. Further falling edges before `cs_n` rises are ignored, and the rising edge of `cs_n` after a full word commits nothing more.
- R5: If `cs_n` rises after 8 to 15 bits, the received bits commit at once in their word positions, starting from bit 15. Every bit not received reads as 0.
- R6: If `cs_n` rises after fewer than 8 bits, the partial word is discarded and all three registers keep their values.
- R7: Command 4'hC loads the code into channel A only.
- R8: Command 4'h1 loads the code into the staging register only. Both outputs stay unchanged.
- R9: Command 4'h8 loads the code into channel B. In the same system clock cycle it loads channel A with the staging register's value as it was before this command.
- R10: Any other command value changes no register.
- R11: Both synchronisers have two stages. An input change made between two system clock edges that completes a commit event appears on the outputs after the fourth following rising edge of `clk`. At no other time do the outputs change.
- R12: Frames sent back to back, with only a short high pulse on `cs_n` between them, are each decoded independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers and outputs are timed by its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (power-on clear) |
| cs_n | input | 1 | Active-low frame select; the frame ends when it rises |
| sclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, most significant bit first |
| code_a | output | 8 | Code driving converter channel A |
| code_b | output | 8 | Code driving converter channel B |

## Verification
The assertions rely on the serial lines being much slower than `clk`. Each `sclk` phase must last several system clock periods, `sdi` must be steady over a falling edge, and `cs_n` must not change in the same system cycle as an `sclk` edge. Only under these conditions do the synchronised edges map one-to-one to serial edges. The stimulus changes every serial line on a falling edge of `clk`. It holds each `sclk` phase for seven system cycles, about 56 ns per bit. It sets `sdi` one system cycle before the rising edge of `sclk`, and it leaves three quiet system cycles around each `cs_n` transition. Under this timing the commit latency is exactly four edges, so the reference model can be compared with the outputs on every cycle.

// File: rtl/dual_dac_serial_pkg.sv
package dual_dac_serial_pkg;

   // Command field values (upper nibble of the serial word)
   typedef enum logic [3:0] {
      CMD_LOAD_BUF = 4'h1,
      CMD_XFER_B   = 4'h8,
      CMD_LOAD_A   = 4'hC
   } dac_cmd_e;

   localparam int unsigned CMD_W = 4;

endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ddc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[gi] <= RST_VAL;
            end else begin
               if (gi == 0) stg[gi] <= d;
               else         stg[gi] <= stg[(gi == 0) ? 0 : gi - 1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ddc_frame_rx.sv
module ddc_frame_rx #(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CMD_W    = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MIN_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   output logic              commit_vld,
   output logic [CMD_W-1:0]  commit_cmd,
   output logic [DATA_W-1:0] commit_data
);

   localparam int unsigned CNT_W    = $clog2(WORD_W + 1);
   localparam int unsigned DATA_LO  = WORD_W - DATA_W;

   logic              cs_q, sclk_q;
   logic [CNT_W-1:0]  cnt;
   logic [CMD_W-1:0]  cmd_q, cmd_nxt;
   logic [DATA_W-1:0] data_q, data_nxt;
   logic              sclk_fall, cs_rise, full, last_bit, early_ok;
   logic [CNT_W-1:0]  cmd_sh, data_sh;

   assign sclk_fall = sclk_q & ~sclk_s;
   assign cs_rise   = ~cs_q & cs_s;
   assign full      = (cnt == CNT_W'(WORD_W));
   assign last_bit  = (cnt == CNT_W'(WORD_W - 1));
   assign early_ok  = (cnt >= CNT_W'(MIN_BITS)) && !full;

   assign cmd_sh  = CNT_W'(CMD_W - 1) - cnt;
   assign data_sh = CNT_W'(WORD_W - 1) - cnt;

   // Place the incoming bit at its word position; reserved bits are dropped
   always_comb begin
      cmd_nxt  = cmd_q;
      data_nxt = data_q;
      if (cnt < CNT_W'(CMD_W))
         cmd_nxt = cmd_q | (CMD_W'(sdi_s) << cmd_sh);
      else if (cnt >= CNT_W'(DATA_LO) && !full)
         data_nxt = data_q | (DATA_W'(sdi_s) << data_sh);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q        <= 1'b1;
         sclk_q      <= 1'b0;
         cnt         <= '0;
         cmd_q       <= '0;
         data_q      <= '0;
         commit_vld  <= 1'b0;
         commit_cmd  <= '0;
         commit_data <= '0;
      end else begin
         cs_q       <= cs_s;
         sclk_q     <= sclk_s;
         commit_vld <= 1'b0;
         if (cs_rise && early_ok) begin
            commit_vld  <= 1'b1;
            commit_cmd  <= cmd_q;
            commit_data <= data_q;
         end
         if (cs_s) begin
            cnt    <= '0;
            cmd_q  <= '0;
            data_q <= '0;
         end else if (sclk_fall && !full) begin
            cnt    <= cnt + 1'b1;
            cmd_q  <= cmd_nxt;
            data_q <= data_nxt;
            if (last_bit) begin
               commit_vld  <= 1'b1;
               commit_cmd  <= cmd_nxt;
               commit_data <= data_nxt;
            end
         end
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(WORD_W)); // R4
   AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vld |=> !commit_vld); // R4
   AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && cnt < CNT_W'(MIN_BITS)) |=> !commit_vld); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (cnt == '0) && !$rose(commit_vld) || $past(cs_rise)); // R2

endmodule

// File: rtl/ddc_latch_bank.sv
module ddc_latch_bank
   import dual_dac_serial_pkg::*;
#(
   parameter int unsigned CMD_W  = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_vld,
   input  logic [CMD_W-1:0]  commit_cmd,
   input  logic [DATA_W-1:0] commit_data,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b
);

   logic [DATA_W-1:0] stage_q;
   logic              is_xfer, is_buf, is_a, is_other;

   assign is_xfer  = (commit_cmd == CMD_XFER_B);
   assign is_buf   = (commit_cmd == CMD_LOAD_BUF);
   assign is_a     = (commit_cmd == CMD_LOAD_A);
   assign is_other = !(is_xfer || is_buf || is_a);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_a  <= '0;
         code_b  <= '0;
         stage_q <= '0;
      end else if (commit_vld) begin
         unique case (1'b1)
            is_xfer: begin
               code_b <= commit_data;
               code_a <= stage_q;
            end
            is_buf:  stage_q <= commit_data;
            is_a:    code_a  <= commit_data;
            default: ;
         endcase
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_vld |=> $stable(code_a) && $stable(code_b) && $stable(stage_q)); // R11
   AST_XFER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && is_xfer) |=> (code_a == $past(stage_q)) && (code_b == $past(commit_data))); // R9
   AST_BUF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && is_buf) |=> $stable(code_a) && $stable(code_b)); // R8
   AST_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && is_a) |=> $stable(code_b) && $stable(stage_q)); // R7
   AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && is_other) |=> $stable(code_a) && $stable(code_b) && $stable(stage_q)); // R10

endmodule

// File: rtl/dual_dac_serial_ctrl.sv
module dual_dac_serial_ctrl #(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned CMD_W       = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MIN_BITS    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b
);

   generate
      if (CMD_W != dual_dac_serial_pkg::CMD_W) begin : g_bad_cmd
         $error("dual_dac_serial_ctrl: CMD_W must match the command encoding");
      end
      if (WORD_W < CMD_W + DATA_W) begin : g_bad_word
         $error("dual_dac_serial_ctrl: WORD_W too small for command and code");
      end
      if (MIN_BITS < 1 || MIN_BITS > WORD_W) begin : g_bad_min
         $error("dual_dac_serial_ctrl: MIN_BITS out of range");
      end
   endgenerate

   logic [2:0]        ser_s;
   logic              commit_vld;
   logic [CMD_W-1:0]  commit_cmd;
   logic [DATA_W-1:0] commit_data;

   ddc_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     (ser_s)
   );

   ddc_frame_rx #(
      .WORD_W   (WORD_W),
      .CMD_W    (CMD_W),
      .DATA_W   (DATA_W),
      .MIN_BITS (MIN_BITS)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_s        (ser_s[2]),
      .sclk_s      (ser_s[1]),
      .sdi_s       (ser_s[0]),
      .commit_vld  (commit_vld),
      .commit_cmd  (commit_cmd),
      .commit_data (commit_data)
   );

   ddc_latch_bank #(
      .CMD_W  (CMD_W),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_vld  (commit_vld),
      .commit_cmd  (commit_cmd),
      .commit_data (commit_data),
      .code_a      (code_a),
      .code_b      (code_b)
   );

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (code_a == '0) && (code_b == '0)); // R1

endmodule

// File: tb/dual_dac_serial_ctrl_tb.sv
module dual_dac_serial_ctrl_tb;

   localparam int LAT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic [7:0] code_a, code_b;

   always #2 clk = ~clk;

   dual_dac_serial_ctrl u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .sclk   (sclk),
      .sdi    (sdi),
      .code_a (code_a),
      .code_b (code_b)
   );

   typedef struct {
      int         due;
      logic [7:0] a;
      logic [7:0] b;
   } upd_t;

   upd_t       pend[$];
   int         cyc = 0;
   int         n_run = 0;
   int         n_fail = 0;
   string      cur_req = "R1";
   logic [7:0] m_a = 8'h00, m_b = 8'h00, m_stage = 8'h00;
   logic [7:0] vis_a = 8'h00, vis_b = 8'h00;
   bit         done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the scheduled model view (R11)
   always @(negedge clk) begin
      if (!done) begin
         while (pend.size() > 0 && pend[0].due <= cyc) begin
            vis_a = pend[0].a;
            vis_b = pend[0].b;
            void'(pend.pop_front());
         end
         n_run++;
         if (code_a !== vis_a || code_b !== vis_b) begin
            n_fail++;
            $display("FAIL R11 %s: actual %h/%h expected %h/%h at cycle %0d",
                     cur_req, code_a, code_b, vis_a, vis_b, cyc);
         end
      end
   end

   task automatic apply_word(input logic [15:0] w);
      upd_t u;
      case (w[15:12])
         4'hC: m_a = w[7:0];
         4'h1: m_stage = w[7:0];
         4'h8: begin m_a = m_stage; m_b = w[7:0]; end
         default: ;
      endcase
      u.due = cyc + LAT;
      u.a = m_a;
      u.b = m_b;
      pend.push_back(u);
   endtask

   // Send nbits of w (MSB first), then extra stray bits, then release select
   task automatic send(input logic [15:0] w, input int nbits, input int extra, input int gap, input string req);
      cur_req = req;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < nbits + extra; i++) begin
         sdi = (i < 16) ? w[15-i] : ~sdi;
         @(negedge clk);
         sclk = 1'b1;
         repeat (7) @(negedge clk);
         sclk = 1'b0;
         if (i == 15) apply_word(w);
         repeat (6) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      cs_n = 1'b1;
      if (nbits >= 8 && nbits < 16)
         apply_word(w & (16'hFFFF << (16 - nbits)));
      repeat (gap) @(negedge clk);
   endtask

   task automatic settle_check(input string req);
      repeat (LAT + 2) @(negedge clk);
      chk(code_a === m_a, req, {8'h00, code_a}, {8'h00, m_a});
      chk(code_b === m_b, req, {8'h00, code_b}, {8'h00, m_b});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(code_a === 8'h00 && code_b === 8'h00, "R1 in reset", {code_a, code_b}, 16'h0000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(code_a === 8'h00 && code_b === 8'h00, "R1 after reset", {code_a, code_b}, 16'h0000);

      // R1: staging register starts at zero, seen through a channel B transfer
      send(16'h80A5, 16, 0, 4, "R1 R9 stage zero");
      settle_check("R1 stage zero");

      // R7, R3: channel A alone, asymmetric code
      send(16'hC03C, 16, 0, 4, "R7 R3 load A");
      settle_check("R7 R3");

      // R8: staging write leaves outputs alone
      send(16'h1F77, 16, 0, 4, "R8 stage only");
      settle_check("R8");

      // R9: paired update
      send(16'h8019, 16, 0, 4, "R9 paired");
      settle_check("R9");
      chk(code_a === 8'h77, "R9 A from stage", {8'h00, code_a}, 16'h0077);

      // R10: unassigned commands
      send(16'h50FF, 16, 0, 4, "R10 cmd 5");
      send(16'h00EE, 16, 0, 4, "R10 cmd 0");
      send(16'hF0DD, 16, 0, 4, "R10 cmd F");
      settle_check("R10");

      // R5: early commit with 12 and 8 bits
      send(16'hC3AB, 12, 0, 4, "R5 12 bits");
      settle_check("R5 12 bits");
      chk(code_a === 8'hA0, "R5 low bits zero", {8'h00, code_a}, 16'h00A0);
      send(16'h8FCD, 8, 0, 4, "R5 8 bits");
      settle_check("R5 8 bits");

      // R6: short frames discarded
      send(16'hC0FF, 7, 0, 4, "R6 7 bits");
      send(16'h80FF, 0, 0, 4, "R6 0 bits");
      settle_check("R6");

      // R2: clocking with select high
      cur_req = "R2 stray";
      for (int k = 0; k < 10; k++) begin
         sdi = k[0];
         repeat (2) @(negedge clk);
         sclk = 1'b1;
         repeat (3) @(negedge clk);
         sclk = 1'b0;
         repeat (3) @(negedge clk);
      end
      settle_check("R2 stray");
      send(16'hC05A, 16, 0, 4, "R2 next frame");
      settle_check("R2 next frame");

      // R4: bits past the sixteenth are ignored
      send(16'hC0C3, 16, 5, 4, "R4 extra bits");
      settle_check("R4");
      send(16'h1011, 16, 3, 4, "R4 extra bits stage");
      send(16'h8022, 16, 0, 4, "R4 check stage");
      settle_check("R4 stage");

      // R12: back-to-back frames with minimal gap
      send(16'h1044, 16, 0, 0, "R12 b2b");
      send(16'hC055, 16, 0, 0, "R12 b2b");
      send(16'h8066, 16, 0, 0, "R12 b2b");
      send(16'hC0F0, 10, 0, 0, "R12 b2b early");
      send(16'h1099, 16, 0, 0, "R12 b2b");
      settle_check("R12");

      repeat (10) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule